// File: doc/BRIEF.md
# TDM Frame Slip Marker

This block watches the elastic stores that sit between each incoming line and the TDM bus, and looks for frame slips. A slip only happens on a frame boundary. When an elastic store runs dry, it replays a whole frame (a repeat slip). When it fills up, it throws a whole frame away (a drop slip). The framers signal each kind of slip with a one-cycle pulse per line.

A repeat slip puts a frame of duplicated data onto the TDM bus. When filtering is enabled, the block clears the per-slot valid flag for every slot of the affected line in that duplicated frame, so downstream consumers can discard it. A drop slip leaves nothing on the bus to mark, so it is only counted. Every slip is counted in a per-line, per-kind saturating counter, and the host empties a counter by reading it.

The slot stream is paced by the TDM timing, not by any consumer. So the valid flag is a plain timed output with a strobe, and there is no ready or back-pressure path. A consumer must accept each flag in the cycle it appears.

Top module: `tdm_slip_marker`

## Requirements
- R1: After reset, `tdm_valid_stb` and `tdm_valid` are low and every slip counter reads 0.
- R2: `tdm_valid_stb` is high exactly one cycle after a cycle with `slot_stb` high, and low otherwise. A slot with `slot_mapped` low always yields `tdm_valid` = 0.
- R3: With `filter_en` low, every mapped slot yields `tdm_valid` = 1, even in frames that follow a slip.
- R4: With `filter_en` high, a `slip_repeat` pulse for line L seen during frame N makes every mapped slot of line L in frame N+1 yield `tdm_valid` = 0. Slots of the other lines stay valid.
- R5: The invalid marking lasts exactly one frame. Frame N+2 is valid again unless a new repeat slip arrived during frame N+1.
- R6: A slip pulse in the same cycle as `frame_sync` belongs to the frame that this `frame_sync` starts. It marks the next frame, not the current one.
- R7: A `slip_drop` pulse never clears `tdm_valid` in any frame.
- R8: Each line has two separate counters: `rd_kind` = 0 selects the repeat-slip counter and `rd_kind` = 1 the drop-slip counter. Each slip pulse adds one to the matching counter, whether or not filtering is on.
- R9: A counter holds at 65535 (all ones for the default 16-bit width) when further slips arrive.
- R10: A cycle with `rd_en` high returns the selected counter's value on `rd_data` in the next cycle and clears that counter. A slip of the same line and kind in the read cycle leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filter_en | input | 1 | Enables invalid marking of repeated frames |
| frame_sync | input | 1 | Marks the first slot of a TDM frame (with slot_stb and slot_idx = 0) |
| slot_stb | input | 1 | One TDM slot is presented this cycle |
| slot_idx | input | SLOT_W (5) | Slot number within the frame |
| slot_mapped | input | 1 | Slot carries data of one of the lines |
| slot_line | input | LINE_W (1) | Line served by the slot |
| slip_repeat | input | NUM_LINES (2) | Per-line repeat-slip pulse (elastic store underflow) |
| slip_drop | input | NUM_LINES (2) | Per-line drop-slip pulse (elastic store overflow) |
| rd_en | input | 1 | Counter read request |
| rd_line | input | LINE_W (1) | Line of the counter to read |
| rd_kind | input | 1 | 0 = repeat counter, 1 = drop counter |
| tdm_valid_stb | output | 1 | tdm_valid holds the flag for the slot strobed in the previous cycle |
| tdm_valid | output | 1 | Slot data valid flag |
| rd_data | output | CNT_W (16) | Counter value returned by a read |

## Verification
The hardest cases to reach are those that depend on where a slip falls relative to the frame boundary. One is a repeat slip that arrives in the very cycle of `frame_sync`. The other is the frame after a marked one, which must come back clean. The driver places slip pulses at chosen slot numbers, including slot 0, across a series of consecutive frames. The scoreboard expects the marking to move one frame later and then go away. Reaching counter saturation needs more than 65,000 pulses, which are driven back to back on one line before the read that empties the counter.

// File: rtl/tdm_slip_pkg.sv
package tdm_slip_pkg;
  typedef enum logic {
    SLIP_REPEAT = 1'b0,
    SLIP_DROP   = 1'b1
  } slip_kind_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/slip_frame_tracker.sv
module slip_frame_tracker #(
  parameter int NUM_LINES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_sync,
  input  logic [NUM_LINES-1:0] slip_repeat,
  output logic [NUM_LINES-1:0] cur_bad
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] bad_q;

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    // pend_q collects repeat slips of the running frame.
    // bad_q flags the frame that is on the bus now.
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[l] <= 1'b0;
        bad_q[l]  <= 1'b0;
      end else if (frame_sync) begin
        bad_q[l]  <= pend_q[l];
        pend_q[l] <= slip_repeat[l];
      end else begin
        pend_q[l] <= pend_q[l] | slip_repeat[l];
      end
    end

    // Lookahead so that slot 0 of the new frame already sees its flag.
    assign cur_bad[l] = frame_sync ? pend_q[l] : bad_q[l];

    assert_sync_slip_deferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_sync && slip_repeat[l]) |=> (pend_q[l] && !bad_q[l]) || (pend_q[l] && $past(pend_q[l])));

    assert_pending_promoted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sync |=> (bad_q[l] == $past(pend_q[l])));
  end

  assert_flag_holds_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> $stable(bad_q));
endmodule

// File: rtl/slip_event_counter.sv
module slip_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (clr)
      cnt_q <= inc ? CNT_ONE : '0;
    else if (inc && cnt_q != CNT_MAX)
      cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt = cnt_q;

  assert_hold_at_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr) |=> cnt_q == CNT_MAX);

  assert_clear_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q <= CNT_ONE);

  assert_step_by_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_ONE));
endmodule

// File: rtl/slot_valid_stage.sv
module slot_valid_stage #(
  parameter int NUM_LINES = 2,
  parameter int LINE_W    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 filter_en,
  input  logic                 slot_stb,
  input  logic                 slot_mapped,
  input  logic [LINE_W-1:0]    slot_line,
  input  logic [NUM_LINES-1:0] cur_bad,
  output logic                 valid_stb,
  output logic                 valid
);
  logic line_bad;
  logic stb_q;
  logic valid_q;

  always_comb begin
    line_bad = 1'b0;
    for (int l = 0; l < NUM_LINES; l++)
      if (slot_line == LINE_W'(l)) line_bad = cur_bad[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      stb_q   <= slot_stb;
      valid_q <= slot_stb && slot_mapped && !(filter_en && line_bad);
    end
  end

  assign valid_stb = stb_q;
  assign valid     = valid_q;

  assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> !valid_stb && !valid);

  assert_unmapped_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !slot_mapped) |=> valid_stb && !valid);

  assert_unfiltered_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && slot_mapped && !filter_en) |=> valid);
endmodule

// File: rtl/tdm_slip_marker.sv
module tdm_slip_marker
  import tdm_slip_pkg::*;
#(
  parameter int NUM_LINES = 2,
  parameter int SLOTS     = 32,
  parameter int CNT_W     = 16,
  localparam int SLOT_W   = idx_width(SLOTS),
  localparam int LINE_W   = idx_width(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 filter_en,
  input  logic                 frame_sync,
  input  logic                 slot_stb,
  input  logic [SLOT_W-1:0]    slot_idx,
  input  logic                 slot_mapped,
  input  logic [LINE_W-1:0]    slot_line,
  input  logic [NUM_LINES-1:0] slip_repeat,
  input  logic [NUM_LINES-1:0] slip_drop,
  input  logic                 rd_en,
  input  logic [LINE_W-1:0]    rd_line,
  input  logic                 rd_kind,
  output logic                 tdm_valid_stb,
  output logic                 tdm_valid,
  output logic [CNT_W-1:0]     rd_data
);
  logic [NUM_LINES-1:0] cur_bad;
  logic [CNT_W-1:0]     rep_cnt  [NUM_LINES];
  logic [CNT_W-1:0]     drop_cnt [NUM_LINES];
  logic [CNT_W-1:0]     rd_sel;
  logic [CNT_W-1:0]     rd_q;

  slip_frame_tracker #(.NUM_LINES(NUM_LINES)) u_tracker (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .slip_repeat(slip_repeat), .cur_bad(cur_bad)
  );

  slot_valid_stage #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .slot_stb(slot_stb),
    .slot_mapped(slot_mapped), .slot_line(slot_line), .cur_bad(cur_bad),
    .valid_stb(tdm_valid_stb), .valid(tdm_valid)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_cnt
    logic hit_line;
    assign hit_line = rd_en && (rd_line == LINE_W'(l));

    slip_event_counter #(.CNT_W(CNT_W)) u_rep (
      .clk(clk), .rst_n(rst_n), .inc(slip_repeat[l]),
      .clr(hit_line && rd_kind == SLIP_REPEAT), .cnt(rep_cnt[l])
    );

    slip_event_counter #(.CNT_W(CNT_W)) u_drop (
      .clk(clk), .rst_n(rst_n), .inc(slip_drop[l]),
      .clr(hit_line && rd_kind == SLIP_DROP), .cnt(drop_cnt[l])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (rd_line == LINE_W'(l))
        rd_sel = (rd_kind == SLIP_DROP) ? drop_cnt[l] : rep_cnt[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (rd_en)
      rd_q <= rd_sel;
  end

  assign rd_data = rd_q;

  assert_frame_sync_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> (slot_stb && slot_idx == '0));

  assert_read_returns_prior_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/tdm_slip_marker_test.sv
module tdm_slip_marker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 2;
  localparam int SL = 32;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          filter_en, frame_sync, slot_stb, slot_mapped;
  logic [4:0]    slot_idx;
  logic [0:0]    slot_line;
  logic [NL-1:0] slip_repeat, slip_drop;
  logic          rd_en, rd_kind;
  logic [0:0]    rd_line;
  logic          tdm_valid_stb, tdm_valid;
  logic [CW-1:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic  exp_q [$];
  string tag_q [$];

  tdm_slip_marker #(.NUM_LINES(NL), .SLOTS(SL), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .filter_en(filter_en), .frame_sync(frame_sync),
    .slot_stb(slot_stb), .slot_idx(slot_idx), .slot_mapped(slot_mapped),
    .slot_line(slot_line), .slip_repeat(slip_repeat), .slip_drop(slip_drop),
    .rd_en(rd_en), .rd_line(rd_line), .rd_kind(rd_kind),
    .tdm_valid_stb(tdm_valid_stb), .tdm_valid(tdm_valid), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each strobed valid flag with the queue.
  always @(negedge clk) begin
    if (rst_n && tdm_valid_stb) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected strobe", 1, 0);
      end else begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, int'(tdm_valid), int'(e));
      end
    end
  end

  // Driver: one frame of slots; mapping skips every fourth slot and
  // alternates lines. exp_bad gives the lines whose data is repeated.
  task automatic run_frame(input logic [NL-1:0] exp_bad, input int inj_slot,
                           input int inj_line, input bit inj_drop, input string req);
    for (int s = 0; s < SL; s++) begin
      logic m;
      logic e;
      @(negedge clk);
      m           = (s % 4) != 3;
      slot_stb    = 1'b1;
      frame_sync  = (s == 0);
      slot_idx    = 5'(s);
      slot_mapped = m;
      slot_line   = 1'(s % 2);
      slip_repeat = '0;
      slip_drop   = '0;
      if (s == inj_slot) begin
        if (inj_drop) slip_drop[inj_line]   = 1'b1;
        else          slip_repeat[inj_line] = 1'b1;
      end
      e = m && !(filter_en && exp_bad[s % 2]);
      exp_q.push_back(e);
      tag_q.push_back(req);
    end
    @(negedge clk);
    slot_stb = 1'b0; frame_sync = 1'b0; slot_mapped = 1'b0;
    slip_repeat = '0; slip_drop = '0;
  endtask

  task automatic read_cnt(input int line, input bit kind, input int exp, input string req);
    @(negedge clk);
    rd_en = 1'b1; rd_line = 1'(line); rd_kind = kind;
    @(negedge clk);
    rd_en = 1'b0;
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; filter_en = 1'b0; frame_sync = 1'b0; slot_stb = 1'b0;
    slot_idx = '0; slot_mapped = 1'b0; slot_line = '0;
    slip_repeat = '0; slip_drop = '0; rd_en = 1'b0; rd_line = '0; rd_kind = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 strobe after reset", int'(tdm_valid_stb), 0);
    check("R1 valid after reset", int'(tdm_valid), 0);
    for (int l = 0; l < NL; l++) begin
      read_cnt(l, 1'b0, 0, "R1 repeat counter");
      read_cnt(l, 1'b1, 0, "R1 drop counter");
    end

    // R3: filter off, a slip still leaves the next frame valid
    run_frame(2'b00, 5, 0, 1'b0, "R2 R3 frame0");
    run_frame(2'b01, -1, 0, 1'b0, "R3 unfiltered after slip");

    // R4/R5: filter on, line 1 repeat marks only the next frame
    filter_en = 1'b1;
    run_frame(2'b00, 10, 1, 1'b0, "R5 stale slip not applied");
    run_frame(2'b10, -1, 0, 1'b0, "R4 line1 repeated frame");
    // R6: slip on frame_sync cycle marks the following frame
    run_frame(2'b00, 0, 0, 1'b0, "R5 R6 frame after mark");
    run_frame(2'b01, 3, 0, 1'b1, "R6 sync slip marks next");
    // R7: drop slip marks nothing
    run_frame(2'b00, -1, 0, 1'b0, "R7 drop no mark");
    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);

    // R8/R10: counts and clear on read
    read_cnt(0, 1'b0, 2, "R8 line0 repeat count");
    read_cnt(1, 1'b0, 1, "R8 line1 repeat count");
    read_cnt(0, 1'b1, 1, "R8 line0 drop count");
    read_cnt(1, 1'b1, 0, "R8 line1 drop count");
    read_cnt(0, 1'b0, 0, "R10 cleared after read");

    // R10: slip in the read cycle survives as 1
    @(negedge clk);
    rd_en = 1'b1; rd_line = 1'b0; rd_kind = 1'b0; slip_repeat[0] = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; slip_repeat = '0;
    check("R10 read with slip returns prior", int'(rd_data), 0);
    read_cnt(0, 1'b0, 1, "R10 simultaneous slip kept");

    // R9: saturation
    for (int i = 0; i < 65540; i++) begin
      @(negedge clk);
      slip_drop[1] = 1'b1;
    end
    @(negedge clk);
    slip_drop = '0;
    read_cnt(1, 1'b1, 65535, "R9 saturated drop count");
    read_cnt(1, 1'b1, 0, "R9 R10 cleared after saturation");
    read_cnt(1, 1'b0, 0, "R8 repeat counter untouched by drops");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule